// File: doc/BRIEF.md
# Stream packet header framer

This block turns a stream of 32-bit samples into a stream of 64-bit packets. Each input packet ends on `s_last`. A 128-bit sideband, read on the first sample of the packet, supplies a 64-bit header template in its upper half and a 64-bit timestamp in its lower half. Each output packet has three parts, in this order:

- one header word;
- a timestamp word, only when the has-time flag is set;
- the payload, packed two samples per 64-bit word.

The length field of a header can only be known once the packet has ended. For this reason the block stores every payload word in a ring buffer. When the last sample arrives, it places the finished header in a small header queue. The output side starts a packet only once that packet's header is in the queue. The 12-bit sequence number is either taken from a counter inside the block or copied from the sideband, chosen by the parameter `SEQ_FROM_SIDE`. A `seq_clear` pulse returns the counter to zero. Everything runs on one clock with a synchronous, active-high reset.

Top module: `pkt_header_framer`

## Requirements
- R1: Output header word fields: bits [63:62] type, bit 61 has-time, bit 60 end-of-burst, [59:48] sequence, [47:32] length in bytes, [31:16] source ID, [15:0] destination ID. Type, has-time, end-of-burst and both IDs are copied from sideband bits [127:64] as seen on the packet's first sample.
- R2: When sideband bit 125 (has-time) is set, the second output word is sideband bits [63:0] from the first sample. When it is clear, no timestamp word is sent.
- R3: The header length field equals 4 × (number of samples received up to and including `s_last`), plus 16 when has-time is set or plus 8 when it is clear. The length value on the sideband is ignored.
- R4: Payload word k carries sample 2k in bits [63:32] and sample 2k+1 in bits [31:0]. For an odd sample count, the final word has zeros in bits [31:0]. `m_last` is high only on the final payload word.
- R5: With `SEQ_FROM_SIDE`=0, the sequence field comes from an internal counter. The counter is 0 after reset, increments by one after each packet's last beat is accepted, and wraps from 4095 to 0.
- R6: With `SEQ_FROM_SIDE`=1, the sequence field is sideband bits [123:112] of that packet.
- R7: A `seq_clear` pulse sets the internal counter to 0, so the next packet header sent carries sequence 0.
- R8: On a packet's first sample, `s_ready` is high only when the buffer has at least `MAX_PKT_WORDS` free words and the header queue has room. Within a packet, it is high while any buffer word is free. `m_valid` stays low until a complete packet's header is queued.
- R9: While `m_valid` is high and `m_ready` is low, `m_data` and `m_last` hold their values. This holds outside a `seq_clear` pulse.
- R10: In the cycle after reset, `m_valid` is 0 and `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_clear | input | 1 | Pulse: zero the sequence counter |
| s_data | input | 32 | Payload sample |
| s_side | input | 128 | Header template [127:64] and timestamp [63:0], read on the first sample |
| s_last | input | 1 | Final sample of the packet |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample accepted when high with `s_valid` |
| m_data | output | 64 | Output packet word |
| m_last | output | 1 | Final word of the output packet |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Output word accepted when high with `m_valid` |

## Verification
The ingress state can drift: a packing half that is left set, or a sample count that is not restarted. Either fault shows up in the very next packet, as a shifted or zero-filled payload word or as a header length that is off by four bytes. A wrong sequence counter shows up in the first header sent after the fault. The bench checks every header, so a counter that skips, holds, or ignores the clear is seen within one packet. A wrong occupancy count in the buffer or the header queue shows up at the ports: either `s_ready` falls at the directed fill points where it should still be high, or output starts before its packet has ended.

// File: rtl/pkt_hdr_pkg.sv
`timescale 1ns/1ps
package pkt_hdr_pkg;
    // Bit positions inside the 64-bit header word
    localparam int HT_BIT  = 61;
    localparam int SEQ_LSB = 48;
    localparam int LEN_LSB = 32;

    typedef enum logic [1:0] {
        EG_HDR = 2'd0,
        EG_TS  = 2'd1,
        EG_PAY = 2'd2
    } eg_state_e;

    // Bytes taken by header plus optional timestamp
    function automatic logic [15:0] hdr_bytes(input logic has_time);
        return has_time ? 16'd16 : 16'd8;
    endfunction
endpackage

// File: rtl/phf_ring.sv
`timescale 1ns/1ps
module phf_ring #(
    parameter int W    = 64,
    parameter int LOG2 = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [W-1:0]    wr_data,
    input  logic            rd_en,
    output logic [W-1:0]    rd_data,
    output logic [LOG2:0]   count
);
    localparam int DEPTH = 1 << LOG2;

    typedef struct packed {
        logic [LOG2:0] wp;
        logic [LOG2:0] rp;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        if (wr_en) ptr_d.wp = ptr_q.wp + 1'b1;
        if (rd_en) ptr_d.rp = ptr_q.rp + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[ptr_q.wp[LOG2-1:0]] <= wr_data;
    end

    assign rd_data = mem[ptr_q.rp[LOG2-1:0]];
    assign count   = ptr_q.wp - ptr_q.rp;
endmodule

// File: rtl/phf_ingress.sv
`timescale 1ns/1ps
module phf_ingress
    import pkt_hdr_pkg::*;
#(
    parameter int BUF_LOG2      = 5,
    parameter int MAX_PKT_WORDS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [31:0]         s_data,
    input  logic [127:0]        s_side,
    input  logic                s_last,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [BUF_LOG2:0]   buf_free,
    input  logic                hq_room,
    output logic                buf_wr,
    output logic [63:0]         buf_wdata,
    output logic                hq_wr,
    output logic [127:0]        hq_wdata
);
    localparam logic [BUF_LOG2:0] MAXW_V = (BUF_LOG2+1)'(MAX_PKT_WORDS);

    typedef struct packed {
        logic        sof;
        logic        half;
        logic [31:0] hold;
        logic [63:0] hdr;
        logic [63:0] ts;
        logic [15:0] nsamp;
    } ing_t;

    localparam ing_t ING_RST = '{sof: 1'b1, half: 1'b0, hold: '0, hdr: '0, ts: '0, nsamp: '0};

    ing_t st_d, st_q;
    logic        fire;
    logic [63:0] cur_hdr, cur_ts;
    logic [15:0] cnt, len;

    always_comb begin
        st_d      = st_q;
        buf_wr    = 1'b0;
        buf_wdata = '0;
        hq_wr     = 1'b0;
        hq_wdata  = '0;
        s_ready   = st_q.sof ? ((buf_free >= MAXW_V) && hq_room) : (buf_free != '0);
        fire      = s_valid && s_ready;
        cur_hdr   = st_q.sof ? s_side[127:64] : st_q.hdr;
        cur_ts    = st_q.sof ? s_side[63:0]   : st_q.ts;
        cnt       = (st_q.sof ? 16'd0 : st_q.nsamp) + 16'd1;
        len       = (cnt << 2) + hdr_bytes(cur_hdr[HT_BIT]);
        if (fire) begin
            st_d.sof   = s_last;
            st_d.hdr   = cur_hdr;
            st_d.ts    = cur_ts;
            st_d.nsamp = cnt;
            if (st_q.half) begin
                buf_wr    = 1'b1;
                buf_wdata = {st_q.hold, s_data};
                st_d.half = 1'b0;
            end else if (s_last) begin
                buf_wr    = 1'b1;
                buf_wdata = {s_data, 32'h0};
            end else begin
                st_d.half = 1'b1;
                st_d.hold = s_data;
            end
            if (s_last) begin
                st_d.half = 1'b0;
                hq_wr     = 1'b1;
                hq_wdata  = {cur_hdr[63:LEN_LSB+16], len, cur_hdr[LEN_LSB-1:0], cur_ts};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ING_RST;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/phf_egress.sv
`timescale 1ns/1ps
module phf_egress
    import pkt_hdr_pkg::*;
#(
    parameter bit SEQ_FROM_SIDE = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         seq_clear,
    input  logic [127:0] hq_entry,
    input  logic         hq_avail,
    output logic         hq_rd,
    input  logic [63:0]  buf_word,
    output logic         buf_rd,
    output logic [63:0]  m_data,
    output logic         m_last,
    output logic         m_valid,
    input  logic         m_ready,
    output logic [11:0]  seq_now
);
    typedef struct packed {
        eg_state_e   st;
        logic [15:0] wcnt;
        logic [11:0] seq;
    } eg_t;

    localparam eg_t EG_RST = '{st: EG_HDR, wcnt: '0, seq: '0};

    eg_t st_d, st_q;
    logic [63:0] hdr, out_hdr;
    logic [15:0] pay_bytes, nwords;

    always_comb begin
        hdr       = hq_entry[127:64];
        pay_bytes = hdr[LEN_LSB+15:LEN_LSB] - hdr_bytes(hdr[HT_BIT]);
        nwords    = (pay_bytes + 16'd7) >> 3;
        out_hdr   = SEQ_FROM_SIDE ? hdr : {hdr[63:SEQ_LSB+12], st_q.seq, hdr[SEQ_LSB-1:0]};

        st_d    = st_q;
        m_valid = 1'b0;
        m_last  = 1'b0;
        m_data  = out_hdr;
        hq_rd   = 1'b0;
        buf_rd  = 1'b0;
        case (st_q.st)
            EG_HDR: begin
                m_valid = hq_avail;
                if (hq_avail && m_ready) begin
                    st_d.st   = hdr[HT_BIT] ? EG_TS : EG_PAY;
                    st_d.wcnt = '0;
                end
            end
            EG_TS: begin
                m_valid = 1'b1;
                m_data  = hq_entry[63:0];
                if (m_ready) st_d.st = EG_PAY;
            end
            EG_PAY: begin
                m_valid = 1'b1;
                m_data  = buf_word;
                m_last  = (st_q.wcnt == nwords - 16'd1);
                if (m_ready) begin
                    buf_rd    = 1'b1;
                    st_d.wcnt = st_q.wcnt + 16'd1;
                    if (m_last) begin
                        hq_rd    = 1'b1;
                        st_d.st  = EG_HDR;
                        st_d.seq = st_q.seq + 12'd1;
                    end
                end
            end
            default: st_d.st = EG_HDR;
        endcase
        if (seq_clear) st_d.seq = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= EG_RST;
        else     st_q <= st_d;
    end

    assign seq_now = st_q.seq;
endmodule

// File: rtl/pkt_header_framer.sv
`timescale 1ns/1ps
module pkt_header_framer #(
    parameter int BUF_LOG2      = 5,
    parameter int HQ_LOG2       = 2,
    parameter int MAX_PKT_WORDS = 16,
    parameter bit SEQ_FROM_SIDE = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         seq_clear,
    input  logic [31:0]  s_data,
    input  logic [127:0] s_side,
    input  logic         s_last,
    input  logic         s_valid,
    output logic         s_ready,
    output logic [63:0]  m_data,
    output logic         m_last,
    output logic         m_valid,
    input  logic         m_ready
);
    localparam logic [BUF_LOG2:0] BUF_DEPTH_V = (BUF_LOG2+1)'(1 << BUF_LOG2);
    localparam logic [HQ_LOG2:0]  HQ_DEPTH_V  = (HQ_LOG2+1)'(1 << HQ_LOG2);

    logic               buf_wr, buf_rd, hq_wr, hq_rd;
    logic [63:0]        buf_wdata, buf_word;
    logic [127:0]       hq_wdata, hq_entry;
    logic [BUF_LOG2:0]  buf_cnt, buf_free;
    logic [HQ_LOG2:0]   hq_cnt;
    logic [11:0]        seq_now;

    assign buf_free = BUF_DEPTH_V - buf_cnt;

    phf_ingress #(.BUF_LOG2(BUF_LOG2), .MAX_PKT_WORDS(MAX_PKT_WORDS)) u_ing (
        .clk(clk), .rst(rst),
        .s_data(s_data), .s_side(s_side), .s_last(s_last), .s_valid(s_valid), .s_ready(s_ready),
        .buf_free(buf_free), .hq_room(hq_cnt != HQ_DEPTH_V),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .hq_wr(hq_wr), .hq_wdata(hq_wdata)
    );

    phf_ring #(.W(64), .LOG2(BUF_LOG2)) u_buf (
        .clk(clk), .rst(rst), .wr_en(buf_wr), .wr_data(buf_wdata),
        .rd_en(buf_rd), .rd_data(buf_word), .count(buf_cnt)
    );

    phf_ring #(.W(128), .LOG2(HQ_LOG2)) u_hq (
        .clk(clk), .rst(rst), .wr_en(hq_wr), .wr_data(hq_wdata),
        .rd_en(hq_rd), .rd_data(hq_entry), .count(hq_cnt)
    );

    phf_egress #(.SEQ_FROM_SIDE(SEQ_FROM_SIDE)) u_eg (
        .clk(clk), .rst(rst), .seq_clear(seq_clear),
        .hq_entry(hq_entry), .hq_avail(hq_cnt != '0), .hq_rd(hq_rd),
        .buf_word(buf_word), .buf_rd(buf_rd),
        .m_data(m_data), .m_last(m_last), .m_valid(m_valid), .m_ready(m_ready),
        .seq_now(seq_now)
    );
endmodule

// File: rtl/phf_checker.sv
`timescale 1ns/1ps
module phf_checker #(
    parameter int BUF_LOG2      = 5,
    parameter int HQ_LOG2       = 2,
    parameter bit SEQ_FROM_SIDE = 1'b0
) (
    input logic                clk,
    input logic                rst,
    input logic                seq_clear,
    input logic [63:0]         m_data,
    input logic                m_last,
    input logic                m_valid,
    input logic                m_ready,
    input logic                s_ready,
    input logic                buf_wr,
    input logic [BUF_LOG2:0]   buf_cnt,
    input logic [HQ_LOG2:0]    hq_cnt,
    input logic [11:0]         seq_now
);
    localparam logic [BUF_LOG2:0] DEPTH_V = (BUF_LOG2+1)'(1 << BUF_LOG2);

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready && !seq_clear) |=> (m_valid && $stable(m_data) && $stable(m_last)));

    p_valid_has_hdr_r8: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> (hq_cnt != '0));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        buf_wr |-> (buf_cnt < DEPTH_V));

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        seq_clear |=> (seq_now == 12'd0));

    p_reset_r10: assert property (@(posedge clk)
        rst |=> (!m_valid && s_ready));

    if (!SEQ_FROM_SIDE) begin : g_seq
        p_seq_step_r5: assert property (@(posedge clk) disable iff (rst)
            (m_valid && m_ready && m_last && !seq_clear) |=> (seq_now == $past(seq_now) + 12'd1));
        p_seq_hold_r5: assert property (@(posedge clk) disable iff (rst)
            (!(m_valid && m_ready && m_last) && !seq_clear) |=> $stable(seq_now));
    end
endmodule

bind pkt_header_framer phf_checker #(
    .BUF_LOG2(BUF_LOG2), .HQ_LOG2(HQ_LOG2), .SEQ_FROM_SIDE(SEQ_FROM_SIDE)
) u_chk (
    .clk(clk), .rst(rst), .seq_clear(seq_clear),
    .m_data(m_data), .m_last(m_last), .m_valid(m_valid), .m_ready(m_ready),
    .s_ready(s_ready), .buf_wr(buf_wr), .buf_cnt(buf_cnt), .hq_cnt(hq_cnt),
    .seq_now(seq_now)
);

// File: tb/pkt_header_framer_tb.sv
`timescale 1ns/1ps
module pkt_header_framer_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         seq_clear = 1'b0;
    logic [31:0]  s_data = '0;
    logic [127:0] s_side = '0;
    logic         s_last = 1'b0;
    logic         s_valid = 1'b0;
    logic         m_ready = 1'b0;
    logic         s_ready, m_last, m_valid;
    logic [63:0]  m_data;
    logic         s_ready_p, m_last_p, m_valid_p;
    logic [63:0]  m_data_p;

    int n_chk = 0, n_fail = 0, cyc = 0, rdy_mode = 1;
    logic [11:0] model_seq = '0;
    logic chk_early = 1'b0;
    // {kind[1:0], last, data[63:0]}; kind 0 header, 1 timestamp, 2 payload
    logic [66:0] q_int[$];
    logic [66:0] q_pt[$];

    always #10 clk = ~clk; // 50 MHz

    pkt_header_framer #(.SEQ_FROM_SIDE(1'b0)) u_dut (
        .clk(clk), .rst(rst), .seq_clear(seq_clear), .s_data(s_data), .s_side(s_side),
        .s_last(s_last), .s_valid(s_valid), .s_ready(s_ready),
        .m_data(m_data), .m_last(m_last), .m_valid(m_valid), .m_ready(m_ready));

    pkt_header_framer #(.SEQ_FROM_SIDE(1'b1)) u_dut_side (
        .clk(clk), .rst(rst), .seq_clear(seq_clear), .s_data(s_data), .s_side(s_side),
        .s_last(s_last), .s_valid(s_valid), .s_ready(s_ready_p),
        .m_data(m_data_p), .m_last(m_last_p), .m_valid(m_valid_p), .m_ready(m_ready));

    task automatic check(input string tag, input logic [64:0] act, input logic [64:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string kind_tag(input logic [1:0] k, input bit pt);
        if (k == 2'd0) return pt ? "R1/R3/R6 header" : "R1/R3/R5 header";
        if (k == 2'd1) return "R2 timestamp";
        return "R4 payload";
    endfunction

    task automatic check_beat(input bit pt, input logic [63:0] d, input logic l);
        logic [66:0] e;
        if ((pt ? q_pt.size() : q_int.size()) == 0) begin
            check("R8 unexpected output beat", {l, d}, 65'h0);
            if ({l, d} == 65'h0) begin n_fail++; $display("FAIL R8 beat with none expected"); end
        end else begin
            e = pt ? q_pt.pop_front() : q_int.pop_front();
            check(kind_tag(e[66:65], pt), {l, d}, e[64:0]);
        end
    endtask

    // Output side: set ready away from the edge, then record beats that fire at the next edge
    always @(negedge clk) begin
        case (rdy_mode)
            0:       m_ready = 1'b0;
            1:       m_ready = 1'b1;
            default: m_ready = (($urandom % 10) < 7);
        endcase
        #2;
        if (!rst) begin
            if (m_valid && m_ready)     check_beat(1'b0, m_data, m_last);
            if (m_valid_p && m_ready)   check_beat(1'b1, m_data_p, m_last_p);
        end
    end

    task automatic send_pkt(input int n, input bit ht, input int gap);
        logic [127:0] side;
        logic [31:0]  sm [64];
        logic [15:0]  len;
        side = {$urandom, $urandom, $urandom, $urandom};
        side[125] = ht;
        for (int i = 0; i < n; i++) sm[i] = $urandom;
        len = 16'(4 * n) + (ht ? 16'd16 : 16'd8);
        q_int.push_back({2'd0, 1'b0, side[127:124], model_seq, len, side[95:64]});
        q_pt.push_back ({2'd0, 1'b0, side[127:124], side[123:112], len, side[95:64]});
        if (ht) begin
            q_int.push_back({2'd1, 1'b0, side[63:0]});
            q_pt.push_back ({2'd1, 1'b0, side[63:0]});
        end
        for (int w = 0; w < (n + 1) / 2; w++) begin
            logic [63:0] wd;
            wd = {sm[2*w], (2*w + 1 < n) ? sm[2*w+1] : 32'h0};
            q_int.push_back({2'd2, (w == (n + 1) / 2 - 1), wd});
            q_pt.push_back ({2'd2, (w == (n + 1) / 2 - 1), wd});
        end
        model_seq = model_seq + 12'd1;
        for (int i = 0; i < n; i++) begin
            if (chk_early && i > 0) check("R8 no output before last", {64'h0, m_valid}, 65'h0);
            if (gap > 0 && ($urandom % 4) == 0) begin
                s_valid = 1'b0;
                repeat (($urandom % gap) + 1) @(negedge clk);
            end
            s_valid = 1'b1; s_data = sm[i]; s_side = side; s_last = (i == n - 1);
            #2;
            while (!s_ready) begin @(negedge clk); #2; end
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic drain();
        while (q_int.size() != 0 || q_pt.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #2;
        check("R10 m_valid after reset", {64'h0, m_valid}, 65'h0);
        check("R10 s_ready after reset", {64'h0, s_ready}, 65'h1);
        @(negedge clk);

        // Directed: output held back until the packet ends (R8), odd/even packing (R4), has-time (R2)
        chk_early = 1'b1;
        send_pkt(6, 1'b0, 3);
        drain();
        send_pkt(5, 1'b1, 0);
        drain();
        chk_early = 1'b0;
        send_pkt(1, 1'b0, 0); send_pkt(2, 1'b1, 0); send_pkt(3, 1'b0, 0);
        drain();

        // Directed: header queue full blocks a new packet (R8)
        rdy_mode = 0;
        for (int k = 0; k < 4; k++) send_pkt(1, k[0], 0);
        s_valid = 1'b1; s_data = 32'h1; s_last = 1'b1;
        #2;
        check("R8 ready low with header queue full", {64'h0, s_ready}, 65'h0);
        s_valid = 1'b0; s_last = 1'b0;
        rdy_mode = 1;
        drain();

        // Directed: buffer cannot take another full packet (R8)
        rdy_mode = 0;
        send_pkt(32, 1'b0, 0);
        send_pkt(32, 1'b1, 0);
        #2;
        check("R8 ready low with buffer full", {64'h0, s_ready}, 65'h0);
        check("R8 output valid once header queued", {64'h0, m_valid}, 65'h1);
        @(negedge clk);
        rdy_mode = 1;
        drain();

        // Random traffic with output backpressure (R1 R2 R3 R4 R5 R6 R9)
        rdy_mode = 2;
        for (int k = 0; k < 300; k++) send_pkt(($urandom % 32) + 1, $urandom % 2, 3);
        drain();

        // Counter clear (R7)
        rdy_mode = 1;
        seq_clear = 1'b1;
        @(negedge clk);
        seq_clear = 1'b0;
        model_seq = '0;
        send_pkt(4, 1'b1, 0);
        drain();

        // Counter wrap past 4095 (R5)
        for (int k = 0; k < 4100; k++) send_pkt(($urandom % 2) + 1, 1'b0, 0);
        drain();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule